// File: doc/BRIEF.md
# JTAG Debug Memory Access Sequencer

This block performs one memory read or one memory write on a target CPU through that CPU's debug port. It drives a four-wire JTAG port (TCK, TMS, TDI, TDO) and a separate target clock line. The target clock steps the target's bus logic. A requester presents a direction flag, a 16-bit address and 16-bit write data. The block then runs a fixed script. The script interleaves 8-bit instruction scans, 16-bit data scans and explicit edges on the target clock. When the script ends, the block raises a one-cycle completion pulse and, for a read, returns the 16-bit word it captured.

Each access first loads a control word into the target's control-signal register. This word chooses between a byte cycle and a word cycle, based on the address. Next, the address goes into the address register. The block then selects the data-to-address register. A write shifts its data and raises the target clock. A read raises and lowers the target clock, then shifts zeros through the data register and keeps what comes back. The three instruction opcodes and the TCK half period are parameters.

Top module: `jtag_mem_seq`

## Requirements
- R1: After reset: busy and done are 0, tck, tms and tdi are 0, the target clock is 1, and rdData is 0x0000.
- R2: Every instruction scan shifts exactly 8 bits and every data scan exactly 16 bits, least significant bit first. Each scan starts in Run-Test/Idle, passes through the Select, Capture, Shift, Exit1 and Update states, and ends back in Run-Test/Idle.
- R3: The control word is 0x2409 for a word read, 0x2419 for a byte read, 0x2408 for a word write and 0x2418 for a byte write. Addresses above 0x00FF are word accesses; addresses 0x00FF and below are byte accesses.
- R4: A write produces this sequence: target clock low (only if it was high), control opcode scan, control word scan, address opcode scan, address scan, data-to-address opcode scan, write data scan, target clock high.
- R5: A read produces this sequence: target clock low (only if it was high), the same three opcode/value scan pairs as a write, target clock high, target clock low, then a data scan of 0x0000. The 16 bits captured from tdo during that last scan appear on rdData in the cycle in which done is 1.
- R6: TCK is high for exactly TCK_HALF clock cycles per pulse. tdi changes only in the cycle in which tck falls. tdo is sampled at the rising transition of tck.
- R7: busy is 1 from the cycle after a request is accepted until done is raised. A request presented while busy is 1 starts no access and causes no port activity.
- R8: done is 1 for exactly one cycle per access. After a write, rdData keeps the value of the last read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request; accepted when busy is 0 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Target address |
| reqData | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last read result |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |
| tclk | output | 1 | Target clock line |

## Verification
The hardest case to reach from the ports is the target-side view: proving that the shifted bits land in the right registers and that the captured read bits map to the correct rdData positions. This needs a full TAP state machine on the far side. The bench models the target TAP. It collects every completed instruction scan and data scan, together with every target-clock edge, and checks them in order against a queue of expected events built from the requirements. It drives tdo from a chosen read value only when the data-to-address register is selected, so that bit order and capture timing are both exposed. Address 0x00FF versus 0x0100, and back-to-back reads in which the target clock is already low, cover the byte/word selection and the skipped clock edge.

// File: rtl/jms_pkg.sv
package jms_pkg;
  parameter int IR_LEN = 8;
  parameter int DR_LEN = 16;
  // TCK pulses spent walking from Run-Test/Idle into the Shift state
  localparam int IR_LEAD = 4;
  localparam int DR_LEAD = 3;
  // Update plus the return to Run-Test/Idle
  localparam int TAIL = 2;

  localparam logic [DR_LEN-1:0] CW_BASE = 16'h2408;
  localparam logic [DR_LEN-1:0] CW_READ = 16'h0001;
  localparam logic [DR_LEN-1:0] CW_BYTE = 16'h0010;
  localparam logic [DR_LEN-1:0] BYTE_LIMIT = 16'h00FF;

  typedef enum logic [2:0] {
    OP_TCLK_LO,
    OP_TCLK_HI,
    OP_IR,
    OP_DR,
    OP_END
  } jms_op_e;

  typedef struct packed {
    logic              scanGo;
    logic              scanIr;
    logic [DR_LEN-1:0] scanData;
    logic              tclkHi;
    logic              tclkLo;
  } jms_strobe_t;
endpackage

// File: rtl/jms_datapath.sv
module jms_datapath
  import jms_pkg::*;
#(
  parameter int TCK_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  jms_strobe_t       strobe,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              tclk,
  output logic              scanDone,
  output logic [DR_LEN-1:0] capture
);
  localparam int IR_TOTAL = IR_LEAD + IR_LEN + TAIL;
  localparam int DR_TOTAL = DR_LEAD + DR_LEN + TAIL;
  localparam int MAX_TOTAL = (IR_TOTAL > DR_TOTAL) ? IR_TOTAL : DR_TOTAL;
  localparam int IW = $clog2(MAX_TOTAL + 1);
  localparam int HW = $clog2(TCK_HALF + 1);

  typedef enum logic [1:0] {D_IDLE, D_LOW, D_HIGH} dp_state_e;

  dp_state_e         state;
  logic [IW-1:0]     idx;
  logic [HW-1:0]     halfCnt;
  logic              irSel;
  logic [DR_LEN-1:0] sreg;
  logic              tckQ, tmsQ, tdiQ, tclkQ, doneQ;

  function automatic logic pulseTms(input logic ir, input int i);
    int lead;
    int len;
    lead = ir ? IR_LEAD : DR_LEAD;
    len  = ir ? IR_LEN : DR_LEN;
    if (i < lead) return ir ? (i < 2) : (i == 0);
    if (i < lead + len) return (i == lead + len - 1);
    return (i == lead + len);
  endfunction

  function automatic logic pulseShift(input logic ir, input int i);
    int lead;
    int len;
    lead = ir ? IR_LEAD : DR_LEAD;
    len  = ir ? IR_LEN : DR_LEN;
    return (i >= lead) && (i < lead + len);
  endfunction

  function automatic int lastPulse(input logic ir);
    return ir ? IR_TOTAL - 1 : DR_TOTAL - 1;
  endfunction

  logic halfEnd;
  assign halfEnd = (halfCnt == HW'(TCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= D_IDLE;
      idx     <= '0;
      halfCnt <= '0;
      irSel   <= 1'b0;
      sreg    <= '0;
      tckQ    <= 1'b0;
      tmsQ    <= 1'b0;
      tdiQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        D_IDLE: begin
          if (strobe.scanGo) begin
            irSel   <= strobe.scanIr;
            sreg    <= strobe.scanData;
            idx     <= '0;
            halfCnt <= '0;
            tmsQ    <= pulseTms(strobe.scanIr, 0);
            tdiQ    <= 1'b0;
            state   <= D_LOW;
          end
        end
        D_LOW: begin
          if (halfEnd) begin
            halfCnt <= '0;
            tckQ    <= 1'b1;
            if (pulseShift(irSel, int'(idx))) sreg <= {tdo, sreg[DR_LEN-1:1]};
            state <= D_HIGH;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        D_HIGH: begin
          if (halfEnd) begin
            halfCnt <= '0;
            tckQ    <= 1'b0;
            if (int'(idx) == lastPulse(irSel)) begin
              tmsQ  <= 1'b0;
              tdiQ  <= 1'b0;
              doneQ <= 1'b1;
              state <= D_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              tmsQ  <= pulseTms(irSel, int'(idx) + 1);
              tdiQ  <= pulseShift(irSel, int'(idx) + 1) ? sreg[0] : 1'b0;
              state <= D_LOW;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= D_IDLE;
      endcase
    end
  end

  // Target clock line, stepped only by the control script
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tclkQ <= 1'b1;
    else if (strobe.tclkHi) tclkQ <= 1'b1;
    else if (strobe.tclkLo) tclkQ <= 1'b0;
  end

  assign tck      = tckQ;
  assign tms      = tmsQ;
  assign tdi      = tdiQ;
  assign tclk     = tclkQ;
  assign scanDone = doneQ;
  assign capture  = sreg;

  // R6: data toward the target moves only together with a falling TCK
  a_r6_tdi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> $fell(tck));

  // R2: mode select holds while TCK is high
  a_r2_tms_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> $stable(tms));

  // R2: a scan request is only taken while no scan runs
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.scanGo && state != D_IDLE) |-> 1'b0);
endmodule

// File: rtl/jms_ctrl.sv
module jms_ctrl
  import jms_pkg::*;
#(
  parameter int          TCK_HALF = 3,
  parameter logic [7:0]  IR_CTRL  = 8'h13,
  parameter logic [7:0]  IR_ADDR  = 8'h83,
  parameter logic [7:0]  IR_DATA  = 8'h85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DR_LEN-1:0] reqAddr,
  input  logic [DR_LEN-1:0] reqData,
  input  logic              scanDone,
  input  logic [DR_LEN-1:0] capture,
  output jms_strobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic [DR_LEN-1:0] rdData
);
  localparam int HW = $clog2(TCK_HALF + 1);

  typedef enum logic [2:0] {C_IDLE, C_ISSUE, C_SCAN, C_HOLD, C_END} ctrl_state_e;

  ctrl_state_e       state;
  logic [3:0]        stepIdx;
  logic              isWrite;
  logic [DR_LEN-1:0] addrQ, dataQ, rdQ, ctrlWord, opVal;
  logic [HW-1:0]     holdCnt;
  logic              doneQ;
  jms_op_e           op;

  always_comb begin
    ctrlWord = CW_BASE;
    if (!isWrite) ctrlWord = ctrlWord | CW_READ;
    if (addrQ <= BYTE_LIMIT) ctrlWord = ctrlWord | CW_BYTE;
  end

  // Script table: steps 0..5 are shared, the tail depends on direction
  always_comb begin
    op    = OP_END;
    opVal = '0;
    unique case (stepIdx)
      4'd0: op = OP_TCLK_LO;
      4'd1: begin op = OP_IR; opVal = DR_LEN'(IR_CTRL); end
      4'd2: begin op = OP_DR; opVal = ctrlWord; end
      4'd3: begin op = OP_IR; opVal = DR_LEN'(IR_ADDR); end
      4'd4: begin op = OP_DR; opVal = addrQ; end
      4'd5: begin op = OP_IR; opVal = DR_LEN'(IR_DATA); end
      4'd6: if (isWrite) begin op = OP_DR; opVal = dataQ; end
            else op = OP_TCLK_HI;
      4'd7: op = isWrite ? OP_TCLK_HI : OP_TCLK_LO;
      4'd8: if (!isWrite) begin op = OP_DR; opVal = '0; end
      default: op = OP_END;
    endcase
  end

  always_comb begin
    strobe.scanGo   = (state == C_ISSUE) && (op == OP_IR || op == OP_DR);
    strobe.scanIr   = (op == OP_IR);
    strobe.scanData = opVal;
    strobe.tclkHi   = (state == C_ISSUE) && (op == OP_TCLK_HI);
    strobe.tclkLo   = (state == C_ISSUE) && (op == OP_TCLK_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= C_IDLE;
      stepIdx <= '0;
      isWrite <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      rdQ     <= '0;
      holdCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (state == C_END);
      unique case (state)
        C_IDLE: if (reqValid) begin
          isWrite <= reqWrite;
          addrQ   <= reqAddr;
          dataQ   <= reqData;
          stepIdx <= '0;
          state   <= C_ISSUE;
        end
        C_ISSUE: begin
          if (op == OP_IR || op == OP_DR) state <= C_SCAN;
          else if (op == OP_END) state <= C_END;
          else begin
            holdCnt <= '0;
            state   <= C_HOLD;
          end
        end
        C_SCAN: if (scanDone) begin
          stepIdx <= stepIdx + 1'b1;
          state   <= C_ISSUE;
        end
        C_HOLD: begin
          if (holdCnt == HW'(TCK_HALF - 1)) begin
            stepIdx <= stepIdx + 1'b1;
            state   <= C_ISSUE;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        C_END: begin
          if (!isWrite) rdQ <= capture;
          state <= C_IDLE;
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  assign busy   = (state != C_IDLE);
  assign done   = doneQ;
  assign rdData = rdQ;

  // R7: an accepted request makes the block busy on the next cycle
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busy) |=> busy);

  // R7: completion is reported only once the block is free again
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a write leaves the read result untouched
  a_r8_rd_held_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && isWrite) |-> $stable(rdData));
endmodule

// File: rtl/jtag_mem_seq.sv
module jtag_mem_seq
  import jms_pkg::*;
#(
  parameter int         TCK_HALF = 3,
  parameter logic [7:0] IR_CTRL  = 8'h13,
  parameter logic [7:0] IR_ADDR  = 8'h83,
  parameter logic [7:0] IR_DATA  = 8'h85
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        tck,
  output logic        tms,
  output logic        tdi,
  input  logic        tdo,
  output logic        tclk
);
  jms_strobe_t       strobe;
  logic              scanDone;
  logic [DR_LEN-1:0] capture;

  jms_ctrl #(
    .TCK_HALF(TCK_HALF),
    .IR_CTRL (IR_CTRL),
    .IR_ADDR (IR_ADDR),
    .IR_DATA (IR_DATA)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .scanDone (scanDone),
    .capture  (capture),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .rdData   (rdData)
  );

  jms_datapath #(
    .TCK_HALF(TCK_HALF)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .tdo      (tdo),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .tclk     (tclk),
    .scanDone (scanDone),
    .capture  (capture)
  );
endmodule

// File: tb/tb_jtag_mem_seq.sv
module tb_jtag_mem_seq;
  localparam int         HALF = 3;
  localparam logic [7:0] IRC  = 8'h13;
  localparam logic [7:0] IRA  = 8'h83;
  localparam logic [7:0] IRD  = 8'h85;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqData = '0;
  logic        busy, done, tck, tms, tdi, tclk;
  logic        tdo = 1'b0;
  logic [15:0] rdData;

  jtag_mem_seq #(.TCK_HALF(HALF), .IR_CTRL(IRC), .IR_ADDR(IRA), .IR_DATA(IRD)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .rdData(rdData), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tclk(tclk)
  );

  int nTests = 0, nFail = 0, timingErr = 0, doneCnt = 0, issued = 0;
  bit finished = 1'b0;
  logic [19:0] expQ[$];
  logic [16:0] resQ[$];
  logic        tclkLevel = 1'b1;
  logic [15:0] nextRead = '0, lastRead = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic seeEvent(input logic [19:0] ev);
    logic [19:0] e;
    if (expQ.size() == 0) check(1'b0, "R4 R5 unexpected port event", ev, 0);
    else begin
      e = expQ.pop_front();
      check(ev == e, "R2 R3 R4 R5 scan or target clock event", ev, e);
    end
  endtask

  // Target-side TAP model
  typedef enum logic [3:0] {T_RESET, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PSDR, T_EX2DR,
                            T_UPDDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PSIR, T_EX2IR, T_UPDIR} tap_e;

  function automatic tap_e tapNext(input tap_e s, input logic m);
    case (s)
      T_RESET: return m ? T_RESET : T_IDLE;
      T_IDLE:  return m ? T_SELDR : T_IDLE;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDDR : T_PSDR;
      T_PSDR:  return m ? T_EX2DR : T_PSDR;
      T_EX2DR: return m ? T_UPDDR : T_SHDR;
      T_UPDDR: return m ? T_SELDR : T_IDLE;
      T_SELIR: return m ? T_RESET : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPDIR : T_PSIR;
      T_PSIR:  return m ? T_EX2IR : T_PSIR;
      T_EX2IR: return m ? T_UPDIR : T_SHIR;
      default: return m ? T_SELDR : T_IDLE;
    endcase
  endfunction

  tap_e        tapState = T_IDLE;
  logic [7:0]  irIn = '0, irCur = '0;
  logic [15:0] drIn = '0, drOut = '0;
  int          irCnt = 0, drCnt = 0;

  always @(posedge tck) begin
    case (tapState)
      T_CAPDR: begin drOut = (irCur == IRD) ? nextRead : 16'h0000; drCnt = 0; end
      T_SHDR:  begin drIn = {tdi, drIn[15:1]}; drOut = drOut >> 1; drCnt++; end
      T_CAPIR: irCnt = 0;
      T_SHIR:  begin irIn = {tdi, irIn[7:1]}; irCnt++; end
      T_UPDDR: begin
        check(drCnt == 16, "R2 data scan length", drCnt, 16);
        seeEvent({4'd2, drIn});
      end
      T_UPDIR: begin
        check(irCnt == 8, "R2 instruction scan length", irCnt, 8);
        irCur = irIn;
        seeEvent({4'd1, 8'h00, irIn});
      end
      default: ;
    endcase
    tapState = tapNext(tapState, tms);
  end

  always @(negedge tck) tdo = drOut[0];

  // Target clock edges, TCK high time and TDI timing, sampled mid-cycle
  logic prevTclk = 1'b1, prevTck = 1'b0, prevTdi = 1'b0, prevDone = 1'b0;
  int   highRun = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tclk !== prevTclk) seeEvent(tclk ? {4'd3, 16'h0} : {4'd4, 16'h0});
      if (tck) highRun++;
      if (prevTck && !tck) begin
        if (highRun != HALF) timingErr++;
        highRun = 0;
      end
      if (tdi !== prevTdi && !(prevTck && !tck)) timingErr++;
      if (prevDone) check(!done, "R8 done lasts one cycle", done, 0);
      if (done) begin
        logic [16:0] r;
        doneCnt++;
        if (resQ.size() == 0) check(1'b0, "R8 done without an access", 1, 0);
        else begin
          r = resQ.pop_front();
          if (!r[16]) begin
            check(rdData == r[15:0], "R5 read data", rdData, r[15:0]);
            lastRead = r[15:0];
          end else begin
            check(rdData == lastRead, "R8 rdData held after write", rdData, lastRead);
          end
        end
        check(tapState == T_IDLE, "R2 TAP back in Run-Test/Idle", tapState, T_IDLE);
        check(expQ.size() == 0, "R4 R5 every script step seen", expQ.size(), 0);
      end
    end
    prevTclk = tclk;
    prevTck  = tck;
    prevTdi  = tdi;
    prevDone = done;
  end

  // Driver: computes the expected event script and issues the request
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [15:0] rv);
    logic [15:0] cw;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    cw = 16'h2408 | (wr ? 16'h0 : 16'h1) | ((a > 16'h00FF) ? 16'h0 : 16'h10);  // R3
    if (tclkLevel) expQ.push_back({4'd4, 16'h0});
    expQ.push_back({4'd1, 8'h00, IRC});
    expQ.push_back({4'd2, cw});
    expQ.push_back({4'd1, 8'h00, IRA});
    expQ.push_back({4'd2, a});
    expQ.push_back({4'd1, 8'h00, IRD});
    if (wr) begin
      expQ.push_back({4'd2, d});
      expQ.push_back({4'd3, 16'h0});
      tclkLevel = 1'b1;
    end else begin
      expQ.push_back({4'd3, 16'h0});
      expQ.push_back({4'd4, 16'h0});
      expQ.push_back({4'd2, 16'h0000});
      tclkLevel = 1'b0;
    end
    resQ.push_back({wr, rv});
    issued++;
    nextRead = rv;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R7 busy after accept", busy, 1);
  endtask

  task automatic waitIdle();
    while (resQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy, "R1 busy after reset", busy, 0);
    check(!done, "R1 done after reset", done, 0);
    check({tck, tms, tdi} == 3'b000, "R1 JTAG lines after reset", {tck, tms, tdi}, 0);
    check(tclk, "R1 target clock after reset", tclk, 1);
    check(rdData == 16'h0, "R1 rdData after reset", rdData, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    access(1'b1, 16'h1234, 16'hBEEF, 16'h0);   // R4 word write
    access(1'b1, 16'h0042, 16'h00A5, 16'h0);   // R3 byte write
    access(1'b0, 16'h0200, 16'h0, 16'h5A3C);   // R5 word read
    access(1'b0, 16'h00FF, 16'h0, 16'h0081);   // R3 boundary byte read, clock already low
    access(1'b1, 16'h0100, 16'h7E01, 16'h0);   // R3 boundary word write, R8 rdData held
    access(1'b0, 16'h0100, 16'h0, 16'hFFFF);   // R5 all ones
    access(1'b0, 16'h8001, 16'h0, 16'h8001);   // R5 end bits

    // R7: request while busy must be ignored
    access(1'b1, 16'h4000, 16'h1357, 16'h0);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0BAD; reqData = 16'hDEAD;
    repeat (5) @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    repeat (50) @(negedge clk);
    check(!busy, "R7 request while busy started nothing", busy, 0);
    check(doneCnt == issued, "R7 completions match accepted requests", doneCnt, issued);
    check(timingErr == 0, "R6 TCK high time and TDI change timing", timingErr, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule